// File: doc/BRIEF.md
# Six-Channel Pulse Width Register Bank

This block measures the high time of six independent pulse-width-modulated input lines, such as the servo-style outputs of a radio receiver, and presents each channel's most recent result as a read-only word on a pipelined memory-mapped read port. A shared prescaler turns the system clock into a measurement tick, normally one per microsecond. Each channel counts ticks while its line is high and reports the width when the line falls. A channel also reports a fault when a high phase or a low phase runs past a guard limit. The low-phase fault covers a transmitter that has been switched off or a broken wire.

Each channel's result is stored in its own register whenever that channel's measurement logic produces a result. A host can poll any register at any time. A read strobe with a 3-bit word address returns the 32-bit word one clock later, together with a valid pulse.

Top module: `pwm_reg_bank`

## Requirements
- R1: After reset, and after any later reset, all six channel registers read as zero and `rd_valid` is low while reset is held.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and low in every other cycle, so each accepted read yields one valid pulse.
- R3: Word addresses 0 to 5 return channels 0 to 5. Addresses 6 and 7 return zero.
- R4: A high pulse that lasts W ticks, with W no greater than GUARD_TICKS, is stored as bit 15 = 0 and bits 14:0 = W.
- R5: A high pulse longer than GUARD_TICKS is stored as bit 15 = 1 and bits 14:0 = GUARD_TICKS. It is reported once per pulse.
- R6: A line that stays low for more than GUARD_TICKS ticks is stored as 0x8000, which is value 0 with the error bit 15 set.
- R7: Bits 31:16 of every read word are zero, because the 16-bit result is zero-extended.
- R8: A channel register changes only when that channel produces a result. Activity on other channels leaves it unchanged.
- R9: One measurement tick occurs every CLKS_PER_TICK clock cycles. A high time of exactly W×CLKS_PER_TICK cycles therefore measures as exactly W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 6 | Pulse lines, one bit per channel; synchronised inside the block |
| rd_addr | input | 3 | Word address of the read |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read word, valid while `rd_valid` is high |
| rd_valid | output | 1 | High one cycle after an accepted read |

## Verification
The bench builds the block with CLKS_PER_TICK = 4 and GUARD_TICKS = 40 and leaves the channel count and widths at their defaults. This shrinks a frame from thousands of microsecond-scale cycles to a few hundred. The guard boundaries (40 and 41 ticks), an over-long high phase, and the low-line timeout all fit in a short run. A tick period above one also exercises the prescaler and makes exact width counts depend on the tick spacing.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
    typedef enum logic [1:0] {
        ST_LOW     = 2'd0,
        ST_HIGH    = 2'd1,
        ST_HOLD_HI = 2'd2,
        ST_HOLD_LO = 2'd3
    } meas_state_e;
endpackage

// File: rtl/pwmbank_tick.sv
module pwmbank_tick #(
    parameter int CLKS_PER_TICK = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_TICK - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             tick;
    } tick_s;

    tick_s tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (tk_q.div == LAST) begin
            tk_d.div  = '0;
            tk_d.tick = 1'b1;
        end else begin
            tk_d.div  = tk_q.div + 1'b1;
            tk_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    assign tick = tk_q.tick;

    generate
        if (CLKS_PER_TICK > 1) begin : g_spacing
            assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pwmbank_meter.sv
module pwmbank_meter
    import pwmbank_pkg::*;
#(
    parameter int VAL_W       = 16,
    parameter int GUARD_TICKS = 2600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwm_pin,
    output logic             rdy,
    output logic [VAL_W-1:0] val
);
    localparam int CNT_W = VAL_W - 1;
    localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_TICKS);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             prev;
        meas_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             rdy;
        logic [VAL_W-1:0] val;
    } meter_s;

    meter_s mt_d, mt_q;
    logic rise, fall;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        mt_d       = mt_q;
        mt_d.sync1 = pwm_pin;
        mt_d.sync2 = mt_q.sync1;
        mt_d.prev  = mt_q.sync2;
        mt_d.rdy   = 1'b0;
        rise = mt_q.sync2 & ~mt_q.prev;
        fall = ~mt_q.sync2 & mt_q.prev;
        nxt  = mt_q.cnt + CNT_W'(tick);
        case (mt_q.state)
            ST_LOW: begin
                if (rise) begin
                    mt_d.state = ST_HIGH;
                    mt_d.cnt   = '0;
                end else if (nxt > GUARD_C) begin
                    mt_d.rdy   = 1'b1;
                    mt_d.val   = {1'b1, {CNT_W{1'b0}}};
                    mt_d.state = ST_HOLD_LO;
                    mt_d.cnt   = '0;
                end else begin
                    mt_d.cnt = nxt;
                end
            end
            ST_HIGH: begin
                if (nxt > GUARD_C) begin
                    mt_d.rdy   = 1'b1;
                    mt_d.val   = {1'b1, GUARD_C};
                    mt_d.state = fall ? ST_LOW : ST_HOLD_HI;
                    mt_d.cnt   = '0;
                end else if (fall) begin
                    mt_d.rdy   = 1'b1;
                    mt_d.val   = {1'b0, nxt};
                    mt_d.state = ST_LOW;
                    mt_d.cnt   = '0;
                end else begin
                    mt_d.cnt = nxt;
                end
            end
            ST_HOLD_HI: begin
                if (fall) begin
                    mt_d.state = ST_LOW;
                    mt_d.cnt   = '0;
                end
            end
            default: begin
                if (rise) begin
                    mt_d.state = ST_HIGH;
                    mt_d.cnt   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mt_q <= '{state: ST_LOW, default: '0};
        else        mt_q <= mt_d;
    end

    assign rdy = mt_q.rdy;
    assign val = mt_q.val;

    assert_err_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && val[VAL_W-1]) |-> (val[CNT_W-1:0] == GUARD_C || val[CNT_W-1:0] == '0));
    assert_good_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !val[VAL_W-1]) |-> (val[CNT_W-1:0] <= GUARD_C));
    assert_single_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank #(
    parameter int NUM_CH        = 6,
    parameter int ADDR_W        = 3,
    parameter int DATA_W        = 32,
    parameter int VAL_W         = 16,
    parameter int CLKS_PER_TICK = 50,
    parameter int GUARD_TICKS   = 2600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [NUM_CH-1:0][VAL_W-1:0] regs;
        logic                         rvalid;
        logic [DATA_W-1:0]            rdata;
    } bank_s;

    bank_s bk_d, bk_q;
    logic              tick;
    logic [NUM_CH-1:0] ch_rdy;
    logic [VAL_W-1:0]  ch_val [NUM_CH];

    pwmbank_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pwmbank_meter #(.VAL_W(VAL_W), .GUARD_TICKS(GUARD_TICKS)) i_meter (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .pwm_pin(pwm_in[c]),
                .rdy    (ch_rdy[c]),
                .val    (ch_val[c])
            );
        end
    endgenerate

    always_comb begin
        bk_d = bk_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_rdy[c]) bk_d.regs[c] = ch_val[c];
        end
        bk_d.rvalid = rd_en;
        bk_d.rdata  = '0;
        if (rd_en && (32'(rd_addr) < NUM_CH)) begin
            bk_d.rdata = DATA_W'(bk_q.regs[rd_addr]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign rd_data  = bk_q.rdata;
    assign rd_valid = bk_q.rvalid;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_data == '0));
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    assert_hole_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (32'(rd_addr) >= NUM_CH)) |=> (rd_data == '0));
    assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:VAL_W] == '0));
endmodule

// File: tb/test_pwm_reg_bank.sv
`timescale 1ns/1ps
module test_pwm_reg_bank;
    localparam int CPT   = 4;
    localparam int GUARD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pwm_in = '0;
    logic [2:0]  rd_addr = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_reg_bank #(.CLKS_PER_TICK(CPT), .GUARD_TICKS(GUARD)) i_pwm_reg_bank (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [7:0]  width;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 8'd10, 32'h0000_000A},
        '{3'd1, 8'd1,  32'h0000_0001},
        '{3'd2, 8'd40, 32'h0000_0028},
        '{3'd3, 8'd25, 32'h0000_0019},
        '{3'd4, 8'd41, 32'h0000_8028},
        '{3'd5, 8'd60, 32'h0000_8028},
        '{3'd0, 8'd33, 32'h0000_0021},
        '{3'd1, 8'd39, 32'h0000_0027}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == 1'b1, "R2 valid after read", 32'(rd_valid), 32'd1);
        chk(rd_data == exp, tag, rd_data, exp);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R2 single valid pulse", 32'(rd_valid), 32'd0);
    endtask

    task automatic pulse(input int ch, input int ticks);
        @(negedge clk);
        pwm_in[ch] = 1'b1;
        repeat (ticks * CPT) @(negedge clk);
        pwm_in[ch] = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 valid low in reset", 32'(rd_valid), 32'd0);
        rd_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) do_read(3'(a), 32'd0, "R1 reset value");

        for (int i = 0; i < 8; i++) begin
            pulse(int'(VECS[i].ch), int'(VECS[i].width));
            if (VECS[i].exp[15]) do_read(VECS[i].ch, VECS[i].exp, "R5 over-long high");
            else                 do_read(VECS[i].ch, VECS[i].exp, "R4 R9 measured width");
        end

        repeat ((GUARD + 4) * CPT + 30) @(negedge clk);
        for (int c = 0; c < 6; c++) do_read(3'(c), 32'h0000_8000, "R6 stuck low");

        pulse(2, 7);
        do_read(3'd3, 32'h0000_8000, "R8 other channel untouched");
        pulse(3, 9);
        do_read(3'd2, 32'h0000_0007, "R8 channel holds own value");
        do_read(3'd3, 32'h0000_0009, "R8 second channel value");
        do_read(3'd6, 32'd0, "R3 address 6 hole");
        do_read(3'd7, 32'd0, "R3 address 7 hole");

        repeat (5) @(negedge clk);
        chk(rd_valid == 1'b0, "R2 no valid without read", 32'(rd_valid), 32'd0);
        pulse(4, 12);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd4;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data[31:16] == 16'd0 && rd_data[15:0] == 16'd12, "R7 zero-extended word",
            rd_data, 32'd12);

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(3'd2, 32'd0, "R1 reset after activity");
        do_read(3'd4, 32'd0, "R1 reset after activity");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule